// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI bus master. Software controls it through a small 32-bit register port with one read strobe and one write strobe. Words are queued in a transmit FIFO. When software allows it, each queued word is shifted out on MOSI while SCLK runs at a rate fixed at build time. A word is sampled back in for every word sent, and that word lands in a receive FIFO. Received words come either from the MISO pin or, in loopback, from the block's own MOSI.

All four clock polarity and phase combinations are supported, and bits can go out most significant first or least significant first. The word width is a parameter: 8, 16 or 32 bits. A hold-off bit lets software load several words before any of them starts on the bus. The active-low slave-select lines come from a register that software writes. They either follow that register at all times or are asserted only while words are shifting. Writing a key value to one offset returns the whole block to its reset state.

Top module: `spi_master_regs`

## Requirements
- R1: After reset, the control register (offset 0x60) reads 0x180. The status register (0x64) reads 0x05, meaning bit0 RX empty, bit1 RX full, bit2 TX empty, bit3 TX full and bit4 fault, which always reads 0. The select register (0x70) reads all ones, SCLK is low and every select output is high.
- R2: While control bit8 (hold-off) is set, writes to 0x68 still enter the TX FIFO but no SCLK edge occurs. Clearing the bit sends the queued words in the order they were written.
- R3: SCLK idles at control bit3 (polarity). With control bit4 (phase) clear, each bit is on MOSI before the leading SCLK edge and is sampled on that edge. With bit4 set, each bit is driven at the leading edge and sampled on the trailing edge. Bits go out most significant first, or least significant first when control bit9 is set.
- R4: With control bit0 (loopback) set, the receive path takes MOSI and ignores MISO. With bit0 clear, MISO is sampled.
- R5: Every word shifted produces exactly one word in the RX FIFO, in the same order. Reading 0x6C pops the oldest word, which appears in the low W bits with zeros above it.
- R6: With control bit7 (manual select) set, the select outputs equal the select register at all times. With bit7 clear, they are all high when idle and equal the register while a word shifts.
- R7: Each FIFO holds 16 words and its status flag shows when it is full. A write to a full TX FIFO is dropped, and a word received while the RX FIFO is full is discarded.
- R8: Writing control bit5 empties the TX FIFO and writing bit6 empties the RX FIFO. Neither bit is stored, so both read back as 0.
- R9: Writing 0x0A to offset 0x40 returns every register and both FIFOs to their reset state. Writing any other value there has no effect.
- R10: No word starts unless control bit1 (enable) and bit2 (master) are both set.
- R11: Each SCLK half-period lasts DIV clock cycles, so the first and last edges of a word are (2W-1)*DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (pops the RX FIFO at 0x6C) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, valid in the same cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | NSS | Active-low slave selects |
| miso | input | 1 | Serial data in |

## Verification
A bench slave watches SCLK and samples MOSI on the edge that the current mode calls for, in all eight combinations of mode and bit order. A design that samples or shifts on the wrong edge would deliver words shifted by one bit, and one with the bit order reversed would deliver mirrored words. The bench also times the spacing of the edges within each word.

The bench fills both FIFOs past 16 words. A design that wrapped its pointers would read back words that had been overwritten. It also checks both gate conditions, hold-off and the enable/master pair, where a leaky gate would start shifting early. The FIFO-flush bits and the soft-reset key are checked to confirm they clear state, and that a non-key value written to the reset offset leaves everything as it was.

// File: rtl/spi_master_regs.sv
module spi_master_regs #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int DIV   = 2,
  parameter int NSS   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     addr,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output logic           sclk,
  output logic           mosi,
  output logic [NSS-1:0] ss_n,
  input  logic           miso
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = $clog2(2 * W);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [9:0] CR_RST = 10'h180;

  logic [9:0]     cr;
  logic [NSS-1:0] ssr;
  logic [W-1:0]   txm [DEPTH];
  logic [W-1:0]   rxm [DEPTH];
  logic [AW:0]    twp, trp, rwp, rrp;
  logic           busy, ph;
  logic [EW-1:0]  ecnt;
  logic [DW-1:0]  dcnt;
  logic [W-1:0]   tsh, rsh;

  wire kill   = !rst_n || (wr_en && addr == 8'h40 && wdata == 32'h0000_000A);
  wire wr_cr  = wr_en && addr == 8'h60;
  wire wr_ss  = wr_en && addr == 8'h70;

  wire tx_empty = twp == trp;
  wire tx_full  = (twp[AW] != trp[AW]) && (twp[AW-1:0] == trp[AW-1:0]);
  wire rx_empty = rwp == rrp;
  wire rx_full  = (rwp[AW] != rrp[AW]) && (rwp[AW-1:0] == rrp[AW-1:0]);

  wire go    = !busy && !tx_empty && cr[1] && cr[2] && !cr[8];
  wire tick  = busy && dcnt == DW'(DIV - 1);
  wire lead  = !ecnt[0];
  wire samp  = tick && (lead ^ cr[4]);
  wire shft  = tick && !(lead ^ cr[4]) && ecnt != '0;
  wire last  = tick && ecnt == EW'(2 * W - 1);
  wire din   = cr[0] ? mosi : miso;

  wire [W-1:0] rnext = cr[9] ? {din, rsh[W-1:1]} : {rsh[W-2:0], din};
  wire [W-1:0] rword = samp ? rnext : rsh;

  wire tx_push = wr_en && addr == 8'h68 && !tx_full;
  wire rx_pop  = rd_en && addr == 8'h6C && !rx_empty;
  wire rx_push = last && !rx_full;

  assign mosi = cr[9] ? tsh[0] : tsh[W-1];
  assign sclk = cr[3] ^ ph;
  assign ss_n = (cr[7] || busy) ? ssr : '1;

  always_comb begin
    case (addr)
      8'h60:   rdata = {22'b0, cr};
      8'h64:   rdata = {27'b0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
      8'h6C:   rdata = 32'(rxm[rrp[AW-1:0]]);
      8'h70:   rdata = 32'(ssr);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (kill) begin
      cr  <= CR_RST;
      ssr <= '1;
    end else begin
      if (wr_cr) cr <= wdata[9:0] & 10'h39F;
      if (wr_ss) ssr <= wdata[NSS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[twp[AW-1:0]] <= wdata[W-1:0];
    if (rx_push) rxm[rwp[AW-1:0]] <= rword;
  end

  always_ff @(posedge clk) begin
    if (kill) begin
      twp <= '0; trp <= '0; rwp <= '0; rrp <= '0;
    end else begin
      if (tx_push) twp <= twp + 1'b1;
      if (go)      trp <= trp + 1'b1;
      if (rx_push) rwp <= rwp + 1'b1;
      if (rx_pop)  rrp <= rrp + 1'b1;
      if (wr_cr && wdata[5]) begin twp <= '0; trp <= '0; end
      if (wr_cr && wdata[6]) begin rwp <= '0; rrp <= '0; end
    end
  end

  always_ff @(posedge clk) begin
    if (kill) begin
      busy <= 1'b0; ph <= 1'b0; ecnt <= '0; dcnt <= '0;
      tsh  <= '0;   rsh <= '0;
    end else if (go) begin
      busy <= 1'b1; ph <= 1'b0; ecnt <= '0; dcnt <= '0;
      tsh  <= txm[trp[AW-1:0]];
    end else if (busy) begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (tick) begin
        ph   <= ~ph;
        ecnt <= ecnt + 1'b1;
        if (last) busy <= 1'b0;
      end
      if (shft) tsh <= cr[9] ? (tsh >> 1) : (tsh << 1);
      if (samp) rsh <= rnext;
    end
  end
endmodule

module spi_master_regs_chk #(
  parameter int AW    = 4,
  parameter int DEPTH = 16,
  parameter int NSS   = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     addr,
  input logic           wr_en,
  input logic [31:0]    wdata,
  input logic [9:0]     cr,
  input logic [NSS-1:0] ssr,
  input logic           busy,
  input logic           sclk,
  input logic [NSS-1:0] ss_n,
  input logic [AW:0]    twp, trp, rwp, rrp
);
  wire [AW:0] tx_cnt = twp - trp;
  wire [AW:0] rx_cnt = rwp - rrp;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= (AW+1)'(DEPTH) && rx_cnt <= (AW+1)'(DEPTH));

  assert_holdoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cr[8] && !busy |=> !busy);

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cr[3]);

  assert_auto_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cr[7] && !busy |-> &ss_n);

  assert_tx_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 8'h60 && wdata[5] |=> tx_cnt == '0);

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 8'h40 && wdata == 32'h0000_000A |=>
      cr == 10'h180 && &ssr && !busy && rx_cnt == '0);
endmodule

bind spi_master_regs spi_master_regs_chk #(.AW(AW), .DEPTH(DEPTH), .NSS(NSS)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .cr(cr), .ssr(ssr), .busy(busy), .sclk(sclk), .ss_n(ss_n),
  .twp(twp), .trp(trp), .rwp(rwp), .rrp(rrp)
);

// File: tb/test_spi_master_regs.sv
module test_spi_master_regs;
  localparam int W = 8, DEPTH = 16, DIV = 2, NSS = 4;
  localparam int WT = 2 * W * DIV + 4;
  localparam logic [31:0] M = (32'h1 << W) - 1;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, miso = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic sclk, mosi;
  logic [NSS-1:0] ss_n;

  spi_master_regs #(.W(W), .DEPTH(DEPTH), .DIV(DIV), .NSS(NSS)) i_spi_master_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .miso(miso));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit cur_cpol = 0, cur_cpha = 0, cur_lsb = 0;
  logic [31:0] mosi_q[$];
  logic [31:0] rx_q[$];

  always @(posedge clk) cyc++;

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, a, e);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic cfg(input logic [31:0] c);
    wreg(8'h60, c);
    cur_cpol = c[3]; cur_cpha = c[4]; cur_lsb = c[9];
  endtask

  // driver: pushes a word and the items the scoreboard should see
  task automatic send(input logic [31:0] d, input bit em, input bit er, input logic [31:0] erx);
    wreg(8'h68, d);
    if (em) mosi_q.push_back(d & M);
    if (er) rx_q.push_back(erx & M);
  endtask

  task automatic pull(input string r);
    logic [31:0] v;
    rreg(8'h6C, v);
    if (rx_q.size() == 0) chk({r, " unexpected rx"}, v, 32'hx);
    else chk(r, v, rx_q.pop_front());
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: bus-side slave collecting MOSI words per the current mode
  logic psclk = 0;
  logic [NSS-1:0] pss = '1;
  int nb = 0, ec = 0, t0 = 0;
  logic [31:0] mw = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      psclk = sclk; pss = '1; nb = 0; ec = 0; mw = 0;
    end else begin
      if (sclk !== psclk && pss != '1) begin
        if (ec == 0) t0 = cyc;
        if ((psclk == cur_cpol) ^ cur_cpha) begin
          if (cur_lsb) mw[nb] = mosi; else mw[W-1-nb] = mosi;
          nb++;
          if (nb == W) begin
            if (mosi_q.size() == 0) chk("R3 unexpected mosi word", mw, 32'hx);
            else chk("R3 mosi word", mw, mosi_q.pop_front());
            nb = 0; mw = 0;
          end
        end
        if (ec == 2 * W - 1) begin
          chk("R11 edge span", cyc - t0, (2 * W - 1) * DIV);
          ec = 0;
        end else ec++;
      end
      psclk = sclk; pss = ss_n;
    end
  end

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    idle(3); rst_n = 1; idle(1);

    // R1 reset state
    rreg(8'h60, v); chk("R1 control", v, 32'h180);
    rreg(8'h64, v); chk("R1 status", v, 32'h05);
    rreg(8'h70, v); chk("R1 select", v, 32'hF);
    chk("R1 sclk", {31'b0, sclk}, 0);
    chk("R1 ss_n", {28'b0, ss_n}, 32'hF);

    // R6 manual select follows register
    wreg(8'h70, 32'hE); idle(1);
    chk("R6 manual ss_n", {28'b0, ss_n}, 32'hE);

    // R2 hold-off then release, R6 auto select
    cfg(32'h107); idle(1);
    chk("R6 auto idle ss_n", {28'b0, ss_n}, 32'hF);
    send(32'h5A, 1, 1, 32'h5A);
    send(32'hC3, 1, 1, 32'hC3);
    send(32'h81, 1, 1, 32'h81);
    idle(200);
    rreg(8'h64, v); chk("R2 held status", v, 32'h01);
    cfg(32'h007); idle(5);
    chk("R6 auto active ss_n", {28'b0, ss_n}, 32'hE);
    idle(3 * WT);
    pull("R2 order 0"); pull("R2 order 1"); pull("R5 third word");
    rreg(8'h64, v); chk("R5 fifos empty", v, 32'h05);

    // R3 modes and bit order, loopback
    for (int m = 0; m < 8; m++) begin
      logic [31:0] c;
      c = 32'h107 | (32'(m[0]) << 3) | (32'(m[1]) << 4) | (32'(m[2]) << 9);
      cfg(c);
      send(32'hA5 ^ 32'(m * 17), 1, 1, 32'hA5 ^ 32'(m * 17));
      send(32'h1E + 32'(m), 1, 1, 32'h1E + 32'(m));
      cfg(c & ~32'h100);
      idle(2 * WT);
      pull("R3 loop word a"); pull("R3 loop word b");
      chk("R3 sclk idle", {31'b0, sclk}, 32'(m[0]));
    end

    // R4 MISO path and loopback ignoring MISO
    cfg(32'h006);
    miso = 1; send(32'h3C, 1, 1, 32'hFF); idle(WT); pull("R4 miso ones");
    miso = 0; send(32'h3C, 1, 1, 32'h00); idle(WT); pull("R4 miso zeros");
    cfg(32'h007);
    miso = 1; send(32'h96, 1, 1, 32'h96); idle(WT); pull("R4 loopback ignores miso");
    miso = 0;

    // R10 enable/master gating
    cfg(32'h005);
    send(32'h44, 1, 1, 32'h44); idle(100);
    rreg(8'h64, v); chk("R10 no enable", v, 32'h01);
    cfg(32'h003); idle(100);
    rreg(8'h64, v); chk("R10 no master", v, 32'h01);
    cfg(32'h007); idle(WT);
    pull("R10 drains once enabled");

    // R7 depth and overflow
    cfg(32'h107);
    for (int i = 0; i < DEPTH; i++) send(32'h10 + 32'(i), 1, 1, 32'h10 + 32'(i));
    send(32'hEE, 0, 0, 0);
    rreg(8'h64, v); chk("R7 tx full", v, 32'h09);
    cfg(32'h007); idle((DEPTH + 1) * WT);
    rreg(8'h64, v); chk("R7 rx full", v, 32'h06);
    for (int i = 0; i < 4; i++) send(32'h70 + 32'(i), 1, 0, 0);
    idle(5 * WT);
    for (int i = 0; i < DEPTH; i++) pull("R7 kept words");
    rreg(8'h64, v); chk("R7 drained", v, 32'h05);

    // R8 FIFO flush bits
    cfg(32'h107);
    send(32'h11, 0, 0, 0); send(32'h22, 0, 0, 0);
    wreg(8'h60, 32'h127);
    rreg(8'h64, v); chk("R8 tx flushed", v, 32'h05);
    rreg(8'h60, v); chk("R8 bit5 reads 0", v, 32'h107);
    send(32'h33, 1, 0, 0); cfg(32'h007); idle(WT);
    rreg(8'h64, v); chk("R8 rx filled", v, 32'h04);
    wreg(8'h60, 32'h047);
    rreg(8'h64, v); chk("R8 rx flushed", v, 32'h05);
    rreg(8'h60, v); chk("R8 bit6 reads 0", v, 32'h007);

    // R9 soft reset key
    cfg(32'h10F); wreg(8'h70, 32'h5);
    send(32'h77, 0, 0, 0);
    wreg(8'h40, 32'h05);
    rreg(8'h60, v); chk("R9 wrong key ignored", v, 32'h10F);
    rreg(8'h64, v); chk("R9 wrong key keeps fifo", v, 32'h01);
    wreg(8'h40, 32'h0A);
    cur_cpol = 0; cur_cpha = 0; cur_lsb = 0;
    rreg(8'h60, v); chk("R9 control default", v, 32'h180);
    rreg(8'h64, v); chk("R9 status default", v, 32'h05);
    rreg(8'h70, v); chk("R9 select default", v, 32'hF);
    chk("R9 sclk low", {31'b0, sclk}, 0);

    idle(10);
    chk("R3 no words left on mosi", 32'(mosi_q.size()), 0);
    finish_run();
  end
endmodule